// File: doc/BRIEF.md
# Reversible Gray Code Counter

A three-bit synchronous counter whose state runs around the reflected Gray code cycle. On every enabled clock edge the state moves one position along that cycle. Between any two neighbouring codes exactly one bit differs, and this includes the wrap at the ends of the cycle. That makes the counter a good fit for a position or phase value that another clock domain or a slow decoder samples.

A direction input selects which way the state walks around the cycle. Reverse stepping undoes the forward step exactly. A terminal flag marks the last code that will be reached before a wrap in the direction currently selected. All three state bits share one clock and change together. A synchronous reset returns the state to the all-zero code.

Top module: `gray_updown_ctr`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `code` becomes 3'b000 after that edge, whatever the values of `en` and `fwd`.
- R2: When `rst` is low and `en` is low at a rising edge, `code` keeps its value across that edge.
- R3: With `fwd` = 1 (forward), each enabled edge moves `code` along 000 → 001 → 011 → 010 → 110 → 111 → 101 → 100 and then back to 000. Position i in this cycle holds the code i XOR (i >> 1).
- R4: With `fwd` = 0 (reverse), each enabled edge moves `code` to the code one position earlier in the R3 cycle, so 3'b000 is followed by 3'b100.
- R5: Every enabled, non-reset edge changes exactly one bit of `code`, and this holds for both wraps.
- R6: A change on `fwd` does not change `code` by itself. The new direction is used on the next enabled edge.
- R7: `last` is high exactly when `fwd` = 1 and `code` = 3'b100, or when `fwd` = 0 and `code` = 3'b000. It follows `fwd` in the same cycle, without waiting for a clock edge.
- R8: Reset takes priority over enable. A reset edge with `en` high still produces 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state bits update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| fwd | input | 1 | Direction: 1 steps forward, 0 steps in reverse |
| code | output | 3 | Current Gray-coded state |
| last | output | 1 | High at the terminal code for the current direction |

## Verification
The bench builds the block with its default three-bit width. At that width the whole cycle has eight codes, so every code, both wraps and every point where the direction can reverse are reached within a few dozen cycles. The scoreboard gets its expected codes from a position counter that the bench keeps itself, converted to Gray code with its own bitwise formula. For each enabled step it also checks that exactly one bit changed from the previously observed code.

// File: rtl/gc_pkg.sv
package gc_pkg;
  localparam int GC_W     = 3;
  localparam int GC_CODES = 1 << GC_W;

  typedef logic [GC_W-1:0] gc_word_t;

  // Position in the cycle -> Gray code
  function automatic gc_word_t to_gray(input gc_word_t b);
    return b ^ (b >> 1);
  endfunction

  // Gray code -> position in the cycle (prefix XOR from the top bit down)
  function automatic gc_word_t from_gray(input gc_word_t g);
    gc_word_t b;
    b[GC_W-1] = g[GC_W-1];
    for (int i = GC_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  localparam gc_word_t GC_FIRST    = '0;
  localparam gc_word_t GC_LAST_FWD = to_gray(gc_word_t'(GC_CODES - 1));
endpackage

// File: rtl/gc_step.sv
module gc_step
  import gc_pkg::*;
(
  input  gc_word_t cur,
  input  logic     fwd,
  output gc_word_t nxt
);
  gc_word_t pos_now;
  gc_word_t pos_next;

  always_comb begin
    pos_now  = from_gray(cur);
    pos_next = fwd ? (pos_now + gc_word_t'(1)) : (pos_now - gc_word_t'(1));
    nxt      = to_gray(pos_next);
  end
endmodule

// File: rtl/gc_term.sv
module gc_term
  import gc_pkg::*;
(
  input  gc_word_t code,
  input  logic     fwd,
  output logic     last
);
  logic at_top;
  logic at_bottom;

  assign at_top    = (code == GC_LAST_FWD);
  assign at_bottom = (code == GC_FIRST);
  assign last      = fwd ? at_top : at_bottom;
endmodule

// File: rtl/gray_updown_ctr.sv
module gray_updown_ctr
  import gc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      fwd,
  output logic [gc_pkg::GC_W-1:0]   code,
  output logic                      last
);
  gc_word_t state_q;
  gc_word_t state_nxt;
  logic     step_taken;

  assign step_taken = en & ~rst;

  gc_step u_step (
    .cur (state_q),
    .fwd (fwd),
    .nxt (state_nxt)
  );

  gc_term u_term (
    .code (state_q),
    .fwd  (fwd),
    .last (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GC_FIRST;
    end else if (en) begin
      state_q <= state_nxt;
    end
  end

  assign code = state_q;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (code == 3'b000));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(code));

  // R5
  single_bit_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_taken |=> ($countones(code ^ $past(code)) == 1));

  // R3
  fwd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step_taken && fwd && code == 3'b100) |=> (code == 3'b000));

  // R4
  rev_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step_taken && !fwd && code == 3'b000) |=> (code == 3'b100));
endmodule

// File: tb/sim_gray_updown_ctr.sv
`timescale 1ns/1ps
module sim_gray_updown_ctr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic       fwd = 1'b1;
  logic [2:0] code;
  logic       last;

  int checks = 0;
  int fails  = 0;
  int pos    = 0;           // bench's own position in the cycle
  logic [2:0] prev_seen = 3'b000;

  logic [2:0] exp_q[$];
  logic       moved_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;    // 50 MHz

  gray_updown_ctr u0 (
    .clk (clk), .rst (rst), .en (en), .fwd (fwd),
    .code (code), .last (last)
  );

  function automatic logic [2:0] pos_code(input int p);
    logic [2:0] b;
    b = p[2:0];
    return {b[2], b[2] ^ b[1], b[1] ^ b[0]};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Driver: apply inputs at the falling edge, check last, queue the expected code
  task automatic drive(input logic r, input logic e, input logic f, input string tag);
    logic exp_last;
    @(negedge clk);
    rst = r; en = e; fwd = f;
    #1;
    if (pos >= 0) begin
      exp_last = f ? (pos == 7) : (pos == 0);
      check("R7 last", last, exp_last);
    end
    if (r) pos = 0;
    else if (e) pos = f ? ((pos + 1) % 8) : ((pos + 7) % 8);
    exp_q.push_back(pos_code(pos));
    moved_q.push_back(!r && e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      logic       m;
      string      t;
      e = exp_q.pop_front();
      m = moved_q.pop_front();
      t = tag_q.pop_front();
      check(t, code, e);
      if (m) check("R5 one bit", $countones(code ^ prev_seen), 1);
      prev_seen = code;
    end
  end

  initial begin
    pos = -1;               // last is unknown before the first reset
    drive(1, 0, 1, "R1 reset");
    drive(1, 1, 0, "R8 reset over enable");
    // R3: full forward lap plus wrap
    for (int i = 0; i < 9; i++) drive(0, 1, 1, "R3 forward");
    // R2: hold with enable low, both directions
    drive(0, 0, 1, "R2 hold");
    drive(0, 0, 0, "R2 hold");
    // R6: direction already changed above, no movement; next enabled edge reverses
    // R4: full reverse lap plus wrap
    for (int i = 0; i < 10; i++) drive(0, 1, 0, "R4 reverse");
    // R6: alternate directions step by step
    for (int i = 0; i < 6; i++) drive(0, 1, i[0], "R6 direction change");
    // R4: reverse wrap from 000 to 100 after a reset
    drive(1, 1, 1, "R1 reset");
    drive(0, 1, 0, "R4 reverse from 000");
    drive(0, 1, 1, "R6 back forward");
    // R2: enable gaps inside forward run
    for (int i = 0; i < 12; i++) drive(0, i % 3 != 0, 1, "R2 R3 gapped run");
    drive(1, 0, 0, "R1 reset");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule